// File: doc/BRIEF.md
# Split-Partition Low-Power Sequence Controller

This block is a sequence controller whose state graph is divided between two cooperating sub-machines. Together they produce the same outputs, cycle for cycle, as one monolithic state machine.

The small sub-machine holds three states, and the controller spends most of its time there. These are an idle state, an armed state and a waiting state. The large sub-machine holds a chain of `LARGE_N` work states. Each sub-machine parks in a dedicated "off" encoding while the other one owns control.

A single ownership flag records which side is active. On a cycle that crosses the partition, three things happen together: the source side drops to its off encoding, the destination side loads its entry state, and the flag flips.

Register enables are synchronous load-enables on one clock. The small side always loads while it owns control. The large side loads only while it owns control, or on the cycle it is entered. The large side sees its two control inputs through a hold stage, which freezes them whenever the small side owns control. The small side takes the inputs directly. The outputs are taken from whichever side owns control.

Top module: `dpm_split_fsm`

## Requirements
- R1: After reset, `state_code` is 0 and `busy` is 0. The small side is in its idle state and the large side is off.
- R2: Small-side behaviour, using state codes idle = 0, armed = 1, waiting = 2. From idle, `go`=1 moves to armed; otherwise it stays in idle. From armed, `go`=1 moves to waiting; otherwise it returns to idle. From waiting with `go`=1 and `sel`=0, it stays in waiting. From waiting with `go`=0, it returns to idle. In the small states, `sel` has no effect except from waiting.
- R3: From waiting, `go`=1 and `sel`=1 together enter the large side. On the next cycle, `state_code` equals 3 (work state 0) and `busy` is 1.
- R4: Large-side behaviour, using state codes 3+k for work state k. With `sel`=1 and k < `LARGE_N`-1, the machine advances to k+1. With `sel`=0 and `go`=1, it restarts at work state 0. With `sel`=0 and `go`=0, it holds. `busy` stays 1 throughout.
- R5: From the last work state (k = `LARGE_N`-1), `sel`=1 returns control to the small side. On the next cycle, `state_code` is 0 and `busy` is 0.
- R6: At every cycle, exactly one side is out of its off encoding. A side whose load-enable is low keeps its state unchanged. A crossing hands control over in a single cycle.
- R7: While the small side owns control, the control inputs seen by the large side stay frozen.
- R8: For any input sequence, `state_code` and `busy` equal those of the equivalent monolithic machine on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Control input: advance / restart request |
| sel | input | 1 | Control input: step / cross request |
| state_code | output | CODE_W | Global state number (small states 0..2, large states 3..2+LARGE_N) |
| busy | output | 1 | High while the large side owns control |

## Verification
The bench builds the controller with `LARGE_N`=4. This keeps the chain short enough that directed vectors and random input traffic both walk the full large chain and exit from its last state many times.

A bench-side monolithic model runs in lockstep with the design. It compares both outputs every cycle across thousands of random `go`/`sel` patterns, so every crossing and every hold case is covered.

Directed vectors pin down each transition rule on its own. A reset is applied in the middle of the large chain to show that ownership returns to the small side.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
    localparam int SMALL_N = 3;

    typedef enum logic [1:0] {
        SM_IDLE = 2'd0,
        SM_ARM  = 2'd1,
        SM_WAIT = 2'd2,
        SM_OFF  = 2'd3
    } small_st_e;

    typedef struct packed {
        logic go;
        logic sel;
    } ctl_t;
endpackage

// File: rtl/dpm_small_fsm.sv
module dpm_small_fsm
    import dpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ld_en,
    input  logic      enter,
    input  ctl_t      ctl,
    output small_st_e st,
    output logic      xfer
);
    typedef struct packed {
        small_st_e st;
    } sm_reg_t;

    sm_reg_t sm_d, sm_q;

    always_comb begin
        sm_d = sm_q;
        xfer = 1'b0;
        if (enter) begin
            sm_d.st = SM_IDLE;
        end else begin
            case (sm_q.st)
                SM_IDLE: if (ctl.go) sm_d.st = SM_ARM;
                SM_ARM:  sm_d.st = ctl.go ? SM_WAIT : SM_IDLE;
                SM_WAIT: begin
                    if (ctl.go && ctl.sel) begin
                        xfer    = 1'b1;
                        sm_d.st = SM_OFF;
                    end else if (!ctl.go) begin
                        sm_d.st = SM_IDLE;
                    end
                end
                default: sm_d.st = SM_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     sm_q.st <= SM_IDLE;
        else if (ld_en) sm_q    <= sm_d;
    end

    assign st = sm_q.st;

    // R6: the off encoding is left only when control is handed back
    assert_off_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sm_q.st == SM_OFF && !enter) |=> sm_q.st == SM_OFF);

    // R3: a crossing parks the small side
    assert_xfer_parks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> sm_q.st == SM_OFF);
endmodule

// File: rtl/dpm_large_fsm.sv
module dpm_large_fsm #(
    parameter int LARGE_N = 6,
    localparam int LW = $clog2(LARGE_N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic          enter,
    input  dpm_pkg::ctl_t ctl,
    output logic [LW-1:0] st,
    output logic          xfer
);
    localparam logic [LW-1:0] LG_OFF  = LW'(LARGE_N);
    localparam logic [LW-1:0] LG_LAST = LW'(LARGE_N - 1);

    typedef struct packed {
        logic [LW-1:0] st;
    } lg_reg_t;

    lg_reg_t lg_d, lg_q;

    always_comb begin
        lg_d = lg_q;
        xfer = 1'b0;
        if (enter) begin
            lg_d.st = '0;
        end else if (lg_q.st != LG_OFF) begin
            if (ctl.sel) begin
                if (lg_q.st == LG_LAST) begin
                    xfer    = 1'b1;
                    lg_d.st = LG_OFF;
                end else begin
                    lg_d.st = lg_q.st + 1'b1;
                end
            end else if (ctl.go) begin
                lg_d.st = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     lg_q.st <= LG_OFF;
        else if (ld_en) lg_q    <= lg_d;
    end

    assign st = lg_q.st;

    // R6: a disabled large side keeps its state
    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> $stable(lg_q.st));

    // R4: the state never leaves the legal range
    assert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lg_q.st <= LG_OFF);
endmodule

// File: rtl/dpm_in_hold.sv
module dpm_in_hold
    import dpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pass,
    input  ctl_t live,
    output ctl_t seen
);
    ctl_t hold_d, hold_q;

    always_comb begin
        hold_d = pass ? live : hold_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign seen = pass ? live : hold_q;

    // R7: frozen inputs while the large side is not the owner
    assert_iso_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass ##1 !pass) |-> $stable(seen));
endmodule

// File: rtl/dpm_split_fsm.sv
module dpm_split_fsm
    import dpm_pkg::*;
#(
    parameter int LARGE_N = 6,
    localparam int LW = $clog2(LARGE_N + 1),
    localparam int CODE_W = $clog2(SMALL_N + LARGE_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              sel,
    output logic [CODE_W-1:0] state_code,
    output logic              busy
);
    typedef struct packed {
        logic own;
    } own_reg_t;

    own_reg_t  own_d, own_q;
    ctl_t      live_ctl, lg_ctl;
    small_st_e sm_st;
    logic [LW-1:0] lg_st;
    logic      sm_xfer, lg_xfer, sm_ld, lg_ld;

    assign live_ctl = '{go: go, sel: sel};
    assign sm_ld    = !own_q.own | lg_xfer;
    assign lg_ld    = own_q.own | sm_xfer;

    dpm_in_hold u_hold (
        .clk(clk), .rst_n(rst_n), .pass(own_q.own),
        .live(live_ctl), .seen(lg_ctl)
    );

    dpm_small_fsm u_small (
        .clk(clk), .rst_n(rst_n), .ld_en(sm_ld), .enter(lg_xfer),
        .ctl(live_ctl), .st(sm_st), .xfer(sm_xfer)
    );

    dpm_large_fsm #(.LARGE_N(LARGE_N)) u_large (
        .clk(clk), .rst_n(rst_n), .ld_en(lg_ld), .enter(sm_xfer),
        .ctl(lg_ctl), .st(lg_st), .xfer(lg_xfer)
    );

    always_comb begin
        own_d = own_q;
        if (sm_xfer || lg_xfer) own_d.own = !own_q.own;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) own_q.own <= 1'b0;
        else        own_q     <= own_d;
    end

    assign state_code = own_q.own ? (CODE_W'(SMALL_N) + CODE_W'(lg_st))
                                  : CODE_W'(sm_st);
    assign busy = own_q.own;

    // R6: exactly one side is out of its off encoding
    assert_one_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sm_st != SM_OFF) != (lg_st != LW'(LARGE_N)));

    // R3: entering the large side lands on work state 0 as owner
    assert_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sm_xfer |=> (own_q.own && lg_st == '0));

    // R5: leaving the large side lands on idle as owner
    assert_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lg_xfer |=> (!own_q.own && sm_st == SM_IDLE));

    // R6: only one side can request a crossing at a time
    assert_single_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sm_xfer && lg_xfer));
endmodule

// File: tb/dpm_split_fsm_bench.sv
module dpm_split_fsm_bench;
    localparam int CLK_P   = 10;
    localparam int LN      = 4;
    localparam int CODE_W  = $clog2(3 + LN);
    localparam int NVEC    = 20;
    localparam int NRAND   = 3000;

    // vector: {go, sel, exp_busy, exp_code[3:0]}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b0_0_0_0000, // R2 idle holds
        7'b1_0_0_0001, // R2 idle -> armed
        7'b1_0_0_0010, // R2 armed -> waiting
        7'b1_0_0_0010, // R2 waiting holds with go
        7'b0_0_0_0000, // R2 waiting -> idle
        7'b1_0_0_0001,
        7'b0_0_0_0000, // R2 armed -> idle
        7'b1_0_0_0001,
        7'b1_0_0_0010,
        7'b1_1_1_0011, // R3 enter large
        7'b0_0_1_0011, // R4 hold
        7'b0_1_1_0100, // R4 advance
        7'b1_0_1_0011, // R4 restart
        7'b0_1_1_0100,
        7'b0_1_1_0101,
        7'b0_1_1_0110, // last work state
        7'b0_0_1_0110, // R4 hold at last
        7'b0_1_0_0000, // R5 exit to idle
        7'b1_1_0_0001, // R2 sel ignored in idle
        7'b1_1_0_0010  // R2 sel ignored in armed
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic sel = 1'b0;
    logic [CODE_W-1:0] state_code;
    logic busy;

    int errors = 0;
    int checks = 0;
    int ref_st = 0;
    bit done = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    dpm_split_fsm #(.LARGE_N(LN)) u_dpm_split_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .sel(sel),
        .state_code(state_code), .busy(busy)
    );

    function automatic int ref_next(int s, bit g, bit se);
        if (s == 0) return g ? 1 : 0;
        if (s == 1) return g ? 2 : 0;
        if (s == 2) return (g && se) ? 3 : (g ? 2 : 0);
        if (se) return (s - 3 == LN - 1) ? 0 : s + 1;
        if (g) return 3;
        return s;
    endfunction

    task automatic check(string req, int exp_code, bit exp_busy);
        checks++;
        if (int'(state_code) != exp_code || busy != exp_busy) begin
            errors++;
            $display("FAIL %s: code=%0d busy=%0b expected code=%0d busy=%0b",
                     req, state_code, busy, exp_code, exp_busy);
        end
    endtask

    task automatic step(bit g, bit se);
        @(negedge clk);
        go = g;
        sel = se;
        ref_st = ref_next(ref_st, g, se);
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        go = 1'b0;
        sel = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        ref_st = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        do_reset();
        check("R1 reset state", 0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][6], VEC[i][5]);
            check($sformatf("R2-R5 vector %0d", i), int'(VEC[i][3:0]), VEC[i][4]);
        end

        // R8 with R6/R7 observed at the ports: lockstep against the model
        for (int i = 0; i < NRAND; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[3], lfsr[1]);
            check("R6/R7/R8 lockstep", ref_st, ref_st >= 3);
        end

        // R1 reset while deep in the large chain
        do_reset();
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        check("R3 entry before reset", 4, 1'b1);
        do_reset();
        check("R1 reset from large side", 0, 1'b0);
        step(1'b0, 1'b1);
        check("R2 sel alone ignored in idle", 0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule